// File: doc/BRIEF.md
# Legacy Expansion Bus I/O Register Slave

This block is a synchronous I/O slave for a 16-bit legacy PC expansion bus. A small file of 16-bit registers sits behind it. The bus master places a 20-bit address on the bus while the latch-enable line is high. The slave tracks that address while the line is high and freezes it when the line falls.

The frozen address is decoded against a fixed window of word registers. While the address enable line is low, a hit drives the active-low 16-bit-device indication. The active-low read strobe makes the slave present register data with an output enable. The active-low write strobe stores the data lines into a register.

Both strobes pass through two-flop synchronizers before their falling edges are detected. Each decoded strobe pulls the ready line low for a programmable number of clocks. The clock-frequency parameter turns the 2.5 microsecond ceiling into a cycle count, and that count caps the stretch. Odd-byte transfers are steered so that the high byte also appears on data lines 7..0.

Top module: `xbus_io_slave`

## Requirements
- R1: The registered address follows `bus_addr` on every clock while `ale` is high and holds its value while `ale` is low. Address changes made while `ale` is low do not alter decode, reads or writes.
- R2: One clock after the registered address lies in the window [BASE, BASE+2*NREGS) with `aen` low, `cs16_n` is 0. Otherwise it is 1.
- R3: While `aen` is high, read and write strobes are ignored. There is no register write, `data_oe` stays 0, `rdy` stays 1 and `cs16_n` is 1.
- R4: During a read strobe to an even address in the window, `data_oe` is 1 and `data_out` equals the addressed register, whose index is (address-BASE)>>1. Outside a decoded read, `data_oe` is 0 and `data_out` is 0.
- R5: A write strobe to an even address in the window with `bhe`=1 stores all of `data_in[15:0]`. With `bhe`=0 it stores only `data_in[7:0]` into bits 7..0 and keeps bits 15..8.
- R6: At an odd address (bit 0 = 1), a read drives the register's bits 15..8 on both `data_out[15:8]` and `data_out[7:0]`. A write stores into bits 15..8 only, taking `data_in[15:8]` when `bhe`=1 and `data_in[7:0]` when `bhe`=0.
- R7: Each decoded strobe start drives `rdy` low for exactly min(STRETCH, CLK_KHZ*25/10000) consecutive clocks, then releases it. An undecoded strobe never drives `rdy` low.
- R8: While `rst` is high, every register clears to 0. The outputs go idle: `cs16_n`=1, `data_oe`=0, `data_out`=0, `rdy`=1.
- R9: Strobes to addresses outside the window change no register and never raise `data_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high (bus reset-drive) |
| ale | input | 1 | Address latch enable, address held while low |
| aen | input | 1 | Address enable, high while a DMA agent owns the bus |
| bus_addr | input | ADDR_W | System address lines |
| bhe | input | 1 | Byte-high enable, active high |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| data_in | input | 16 | Data lines as driven by the master |
| cs16_n | output | 1 | 16-bit device indication, active low |
| data_out | output | 16 | Read data toward the data lines |
| data_oe | output | 1 | Output enable for `data_out` |
| rdy | output | 1 | Ready line, low stretches the cycle |

## Verification
Random accesses mix reads and writes at even and odd addresses with both `bhe` levels. Addresses fall mostly inside the window and some just beyond it, and `aen` is high now and then. This separates the word, low-byte and steered high-byte paths, and separates window hits from misses and DMA-owned cycles. Directed cases cover three further points: an address changed after the latch has closed, a second instance whose stretch request exceeds the 2.5 microsecond cap (so the capped count differs from the requested one), and a reset after registers were written.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef logic [15:0] word_t;

  // Read steering: an odd-byte access also places the high byte on lines 7..0.
  function automatic word_t steer_rd(word_t w, logic odd);
    return odd ? {w[15:8], w[15:8]} : w;
  endfunction

  // Write merge according to address bit 0 and the byte-high enable.
  function automatic word_t merge_wr(word_t old, word_t bus, logic odd, logic hi_en);
    word_t r;
    if (odd)        r = {(hi_en ? bus[15:8] : bus[7:0]), old[7:0]};
    else if (hi_en) r = bus;
    else            r = {old[15:8], bus[7:0]};
    return r;
  endfunction
endpackage

// File: rtl/xbus_strobe_sync.sv
module xbus_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic active,
  output logic start
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], strobe_n};
  end

  assign active = ~pipe[STAGES-1];
  assign start  = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/xbus_addr_dec.sv
module xbus_addr_dec #(
  parameter int unsigned ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE = 'h300,
  parameter int unsigned NREGS = 8,
  localparam int unsigned IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              aen,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              odd,
  output logic              cs16_n
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * NREGS);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] offset;
  logic              in_win;

  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (ale) addr_q <= addr_in;
  end

  assign offset = addr_q - BASE;
  assign in_win = (addr_q >= BASE) && (offset < SPAN);
  assign hit    = in_win & ~aen;
  assign idx    = offset[IDX_W:1];
  assign odd    = addr_q[0];

  always_ff @(posedge clk) begin
    if (rst) cs16_n <= 1'b1;
    else     cs16_n <= ~hit;
  end

  // R1: address is frozen while the latch enable is low
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(ale) && !$past(rst)) |-> $stable(addr_q));
  // R3: a DMA-owned bus never shows the 16-bit indication
  p_no_cs_dma_r3: assert property (@(posedge clk) disable iff (rst)
    $past(aen) |-> cs16_n);
endmodule

// File: rtl/xbus_ready_timer.sv
module xbus_ready_timer #(
  parameter int unsigned CLK_KHZ = 50000,
  parameter int unsigned STRETCH = 4,
  localparam int unsigned LIMIT = (CLK_KHZ * 25) / 10000,
  localparam int unsigned HOLD  = (STRETCH < LIMIT) ? STRETCH : LIMIT,
  localparam int unsigned CNT_W = (HOLD > 1) ? $clog2(HOLD + 1) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic rdy
);
  logic [CNT_W-1:0] cnt;

  generate
    if (HOLD == 0) begin : g_none
      always_ff @(posedge clk) begin
        cnt <= '0;
        rdy <= 1'b1;
      end
    end else begin : g_timer
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
          rdy <= 1'b1;
        end else if (start) begin
          cnt <= CNT_W'(HOLD - 1);
          rdy <= 1'b0;
        end else if (!rdy) begin
          if (cnt == '0) rdy <= 1'b1;
          else           cnt <= cnt - 1'b1;
        end
      end
    end
  endgenerate

  // Independent watch on the length of each low run.
  int unsigned low_run;
  always_ff @(posedge clk) begin
    if (rst || rdy) low_run <= 0;
    else            low_run <= low_run + 1;
  end

  // R7: ready is never held low beyond the capped count
  p_ready_cap_r7: assert property (@(posedge clk) disable iff (rst)
    low_run <= LIMIT);
  p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!start && low_run >= HOLD) |-> rdy);
endmodule

// File: rtl/xbus_io_slave.sv
module xbus_io_slave #(
  parameter int unsigned ADDR_W  = 20,
  parameter logic [ADDR_W-1:0] BASE = 'h300,
  parameter int unsigned NREGS   = 8,
  parameter int unsigned CLK_KHZ = 50000,
  parameter int unsigned STRETCH = 4,
  localparam int unsigned IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              aen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bhe,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [15:0]       data_in,
  output logic              cs16_n,
  output logic [15:0]       data_out,
  output logic              data_oe,
  output logic              rdy
);
  import xbus_pkg::*;

  logic             hit, odd;
  logic [IDX_W-1:0] idx;
  logic             rd_act, rd_start, wr_act, wr_start;
  word_t            regs [NREGS];

  xbus_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .NREGS(NREGS)) u_dec (
    .clk(clk), .rst(rst), .ale(ale), .aen(aen), .addr_in(bus_addr),
    .hit(hit), .idx(idx), .odd(odd), .cs16_n(cs16_n));

  xbus_strobe_sync u_rd_sync (
    .clk(clk), .rst(rst), .strobe_n(ior_n), .active(rd_act), .start(rd_start));
  xbus_strobe_sync u_wr_sync (
    .clk(clk), .rst(rst), .strobe_n(iow_n), .active(wr_act), .start(wr_start));

  xbus_ready_timer #(.CLK_KHZ(CLK_KHZ), .STRETCH(STRETCH)) u_rdy (
    .clk(clk), .rst(rst), .start((rd_start | wr_start) & hit), .rdy(rdy));

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_start && hit) begin
      regs[idx] <= merge_wr(regs[idx], data_in, odd, bhe);
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= rd_act & hit;
      data_out <= (rd_act & hit) ? steer_rd(regs[idx], odd) : '0;
    end
  end

  // R4: data is only enabled for a decoded cycle
  p_oe_decoded_r4: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !cs16_n);
  // R3: DMA ownership blocks the read enable
  p_no_oe_dma_r3: assert property (@(posedge clk) disable iff (rst)
    $past(aen) |-> !data_oe);
  // R8: outputs idle right after reset
  p_reset_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs16_n && !data_oe && rdy && data_out == '0));
endmodule

// File: tb/xbus_io_slave_bench.sv
module xbus_io_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] BASE = 20'h00300;
  localparam int NREGS = 8;
  localparam int HOLD_A = 4;   // STRETCH 4, cap 125
  localparam int HOLD_B = 10;  // STRETCH 50, cap 4000*25/10000 = 10

  logic clk = 0, rst = 1, ale = 0, aen = 0, bhe = 0, ior_n = 1, iow_n = 1;
  logic [19:0] bus_addr = '0;
  logic [15:0] data_in = '0;
  logic cs16_n, data_oe, rdy, cs16_b, oe_b, rdy_b;
  logic [15:0] data_out, dout_b;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [NREGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_io_slave #(.BASE(BASE), .NREGS(NREGS), .CLK_KHZ(50000), .STRETCH(4)) u_xbus_io_slave (
    .clk(clk), .rst(rst), .ale(ale), .aen(aen), .bus_addr(bus_addr), .bhe(bhe),
    .ior_n(ior_n), .iow_n(iow_n), .data_in(data_in), .cs16_n(cs16_n),
    .data_out(data_out), .data_oe(data_oe), .rdy(rdy));

  xbus_io_slave #(.BASE(BASE), .NREGS(NREGS), .CLK_KHZ(4000), .STRETCH(50)) u_xbus_io_slave_cap (
    .clk(clk), .rst(rst), .ale(ale), .aen(aen), .bus_addr(bus_addr), .bhe(bhe),
    .ior_n(ior_n), .iow_n(iow_n), .data_in(data_in), .cs16_n(cs16_b),
    .data_out(dout_b), .data_oe(oe_b), .rdy(rdy_b));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_win(logic [19:0] a);
    return (a >= BASE) && ((a - BASE) < 20'(2*NREGS));
  endfunction

  function automatic logic [15:0] exp_rd(logic [19:0] a);
    logic [15:0] w = model[(a - BASE) >> 1];
    return a[0] ? {w[15:8], w[15:8]} : w;
  endfunction

  function automatic logic [15:0] exp_wr(logic [15:0] old, logic [15:0] d, bit o, bit b);
    if (o)      return {(b ? d[15:8] : d[7:0]), old[7:0]};
    else if (b) return d;
    else        return {old[15:8], d[7:0]};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(logic [19:0] a, bit dma);
    aen = dma; ale = 1; bus_addr = a;
    cyc(2);
    ale = 0;
    cyc(2);
    chk("R2 cs16_n", cs16_n, !(in_win(a) && !dma));
  endtask

  // Strobe on the currently latched address `a`
  task automatic strobe(bit wr, logic [19:0] a, bit b, bit dma, logic [15:0] d);
    int lo_a = 0, lo_b = 0;
    bit h = in_win(a) && !dma;
    bhe = b; data_in = d;
    cyc(1);
    if (wr) iow_n = 0; else ior_n = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (!rdy) lo_a++;
      if (!rdy_b) lo_b++;
      if (i == 6 && !wr) begin
        chk(dma ? "R3 oe" : (h ? "R4 oe" : "R9 oe"), data_oe, h);
        if (h) chk(a[0] ? "R6 steer" : "R4 data", data_out, exp_rd(a));
      end
    end
    iow_n = 1; ior_n = 1;
    cyc(5);
    chk(dma ? "R3 rdy" : "R7 rdy A", lo_a, h ? HOLD_A : 0);
    chk(dma ? "R3 rdy cap" : "R7 rdy cap", lo_b, h ? HOLD_B : 0);
    chk("R4 idle oe", data_oe, 0);
    if (wr && h) begin
      int k = (a - BASE) >> 1;
      model[k] = exp_wr(model[k], d, a[0], b);
    end
  endtask

  task automatic access(bit wr, logic [19:0] a, bit b, bit dma, logic [15:0] d);
    set_addr(a, dma);
    strobe(wr, a, b, dma, d);
  endtask

  task automatic read_all(string req);
    for (int k = 0; k < NREGS; k++) begin
      set_addr(BASE + 20'(2*k), 0);
      bhe = 1; ior_n = 0;
      cyc(7);
      chk(req, data_out, model[k]);
      ior_n = 1;
      cyc(5);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd77));
    for (int k = 0; k < NREGS; k++) model[k] = '0;
    cyc(4);
    // R8: idle state during reset
    chk("R8 cs16_n", cs16_n, 1);
    chk("R8 oe", data_oe, 0);
    chk("R8 rdy", rdy, 1);
    chk("R8 dout", data_out, 0);
    rst = 0;
    cyc(2);

    // R5: word and low-byte writes at even addresses
    access(1, BASE + 20'h0, 1, 0, 16'hA55A);
    access(1, BASE + 20'h2, 1, 0, 16'h1234);
    access(1, BASE + 20'h2, 0, 0, 16'hFFCD);
    access(0, BASE + 20'h2, 1, 0, 16'h0);
    chk("R5 low byte", model[1], 16'h12CD);
    // R6: odd-byte writes, both lane choices, then steered read
    access(1, BASE + 20'h5, 1, 0, 16'h7E00);
    access(1, BASE + 20'h7, 0, 0, 16'h0099);
    access(0, BASE + 20'h5, 0, 0, 16'h0);
    access(0, BASE + 20'h7, 1, 0, 16'h0);
    // R3: DMA-owned write ignored, seen at the ports by a later read
    access(1, BASE + 20'h0, 1, 1, 16'hDEAD);
    access(0, BASE + 20'h0, 1, 0, 16'h0);
    // R9: write just beyond the window
    access(1, BASE + 20'(2*NREGS), 1, 0, 16'hBEEF);
    read_all("R9 no write");

    // R1: address changed after the latch closed
    set_addr(BASE + 20'h6, 0);
    bus_addr = BASE + 20'h100;
    cyc(3);
    chk("R1 cs16 held", cs16_n, 0);
    strobe(1, BASE + 20'h6, 1, 0, 16'h4242);
    read_all("R1 write target");

    // Random mix
    for (int n = 0; n < 60; n++) begin
      logic [19:0] a = BASE + 20'($urandom % (2*NREGS + 6));
      bit dma = ($urandom % 6) == 0;
      access($urandom % 2, a, $urandom % 2, dma, 16'($urandom));
    end
    read_all("R5 random final");

    // R8: reset clears registers
    rst = 1; cyc(3); rst = 0; cyc(2);
    for (int k = 0; k < NREGS; k++) model[k] = '0;
    read_all("R8 cleared");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule